// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers event indications from the neighbouring logic of an audio transceiver into two byte-wide status registers and drives one interrupt pin. Each event source has its own enable bit and its own two-bit trigger selection. The selection can be rising edge, falling edge or level. Edge-triggered status bits stay set until software reads their register. Level-triggered bits track the present condition. One status bit is a composite receiver-error source: it is the OR of seven receiver error lines, and each of those lines has its own enable bit.

A simple byte register port carries a write strobe, a read strobe and an address. Through it software writes the pin style, the enables and the trigger selections, and reads the status. The interrupt pin can be driven active high, driven active low, or used as an open-drain output. In the open-drain style the data is held low and only the output enable toggles.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) all configuration registers and status bits are zero, the pin style is active high, irq_pin_o is 0 and irq_oe_o is 1.
- R2: Register addresses are: 0 control (pin style in bits [1:0], other bits read 0), 1 status one, 2 status two, 3 enable one, 4 trigger-high one, 5 trigger-low one, 6 enable two, 7 trigger-high two, 8 trigger-low two, 9 error enable (bits [6:0]). A write takes effect at the clock edge of the strobe. Read data appears on reg_rdata_o one clock after the read strobe, and every writable register reads back what was written.
- R3: Status one has bit 7 = transmitter slip, bit 6 = output-port slip, bit 2 = channel-status D-to-E transfer, bit 1 = channel-status E-to-F transfer, bit 0 = receiver error. Status two has bit 3 = user-data D-to-E transfer, bit 2 = user-data E-to-F transfer, bit 1 = new Q block. All other status bits read 0.
- R4: Each status bit takes its trigger code from {trigger-high bit, trigger-low bit}. Code 00 latches the bit on a 0-to-1 change of its source, and code 01 latches it on a 1-to-0 change. A latched bit stays set until its status register is read, and that read clears it.
- R5: Codes 10 and 11 make the status bit equal to its source as sampled at the previous clock edge. Reads do not clear such a bit, and a bit in these modes keeps nothing latched.
- R6: An edge that is detected in the same cycle as a read of its status register is not lost. The read returns the old value, and the bit is set afterwards.
- R7: The receiver-error source is the OR of rx_err_i bits that are enabled in the error-enable register. Bit 6 is Q CRC, 5 channel-status CRC, 4 PLL unlock, 3 validity, 2 confidence, 1 bi-phase and 0 parity.
- R8: The interrupt is pending only while some status bit is set and its enable bit (same position in the enable register) is 1.
- R9: Pin style 0 gives pin = pending with oe = 1. Style 1 gives pin = not pending with oe = 1. Styles 2 and 3 give pin = 0 with oe = pending.
- R10: Writes to status or unmapped addresses change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid one clock after the strobe |
| tx_slip_i | input | 1 | Transmitter source slip event |
| out_slip_i | input | 1 | Serial output slip event |
| cs_de_i | input | 1 | Channel-status D-to-E transfer event |
| cs_ef_i | input | 1 | Channel-status E-to-F transfer event |
| ud_de_i | input | 1 | User-data D-to-E transfer event |
| ud_ef_i | input | 1 | User-data E-to-F transfer event |
| qblk_i | input | 1 | New Q block available |
| rx_err_i | input | ERR_W | Receiver error lines |
| irq_pin_o | output | 1 | Interrupt pin data |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its default parameters: a four-bit address and the full seven-line error vector. With these values every mapped register and all seven error enables can be reached. That includes the masking of the top error-enable bit on readback and a read of an unmapped address (15). A table run in level mode covers the bit layout of both status registers across eleven source patterns. Directed tests then cover edge latching, read-clear, the read/edge race, the reserved trigger code and all four pin styles.

// File: rtl/irq_pkg.sv
// Package: shared constants and encodings for the interrupt status controller.
// Assumes 8-bit registers; status bit positions are fixed by the event layout.
package irq_pkg;
    localparam int REG_W = 8;

    // Implemented status bits of the two status registers
    localparam logic [REG_W-1:0] IMPL_ONE = 8'b1100_0111;
    localparam logic [REG_W-1:0] IMPL_TWO = 8'b0000_1110;

    // Trigger codes {high, low}
    localparam logic [1:0] TRIG_RISE = 2'b00;
    localparam logic [1:0] TRIG_FALL = 2'b01;

    typedef enum logic [1:0] {
        STY_HIGH = 2'd0,
        STY_LOW  = 2'd1,
        STY_OD   = 2'd2,
        STY_RSV  = 2'd3
    } pin_style_e;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_STAT1 = 4'd1,
        A_STAT2 = 4'd2,
        A_MASK1 = 4'd3,
        A_TRH1  = 4'd4,
        A_TRL1  = 4'd5,
        A_MASK2 = 4'd6,
        A_TRH2  = 4'd7,
        A_TRL2  = 4'd8,
        A_ERREN = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/irq_src_cell.sv
// Module: one status bit with selectable rising, falling or level trigger.
// Assumes src_i is synchronous to clk; clr_i is the read strobe of its register.
module irq_src_cell
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_i,
    input  logic [1:0] mode_i,
    input  logic       clr_i,
    output logic       stat_o
);
    logic prev_q;
    logic latch_q;
    logic hit;

    // Edge detection against the previous sample for the selected edge
    always_comb begin
        case (mode_i)
            TRIG_RISE: hit = src_i & ~prev_q;
            TRIG_FALL: hit = ~src_i & prev_q;
            default:   hit = 1'b0;
        endcase
    end

    // Sample the source every cycle (edge reference and level value)
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i;
    end

    // Sticky latch: set by an edge, cleared by a read; an edge wins a race
    always_ff @(posedge clk) begin
        if (!rst_n)         latch_q <= 1'b0;
        else if (mode_i[1]) latch_q <= 1'b0;
        else                latch_q <= (latch_q & ~clr_i) | hit;
    end

    assign stat_o = mode_i[1] ? prev_q : latch_q;
endmodule

// File: rtl/irq_stat_bank.sv
// Module: one status register built from per-bit trigger cells.
// Assumes IMPL marks the implemented positions; the others read as zero.
module irq_stat_bank
    import irq_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] trig_hi_i,
    input  logic [REG_W-1:0] trig_lo_i,
    input  logic             clr_i,
    output logic [REG_W-1:0] stat_o
);
    logic [REG_W-1:0] raw;

    for (genvar k = 0; k < REG_W; k++) begin : g_bit
        irq_src_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[k]),
            .mode_i ({trig_hi_i[k], trig_lo_i[k]}),
            .clr_i  (clr_i),
            .stat_o (raw[k])
        );
    end

    assign stat_o = raw & IMPL;
endmodule

// File: rtl/irq_err_merge.sv
// Module: folds the enabled receiver error lines into one error source.
// Assumes error lines are synchronous levels.
module irq_err_merge #(
    parameter int ERR_W = 7
) (
    input  logic [ERR_W-1:0] err_i,
    input  logic [ERR_W-1:0] en_i,
    output logic             any_o
);
    assign any_o = |(err_i & en_i);
endmodule

// File: rtl/irq_pin_drv.sv
// Module: maps the pending condition onto pin data and output enable.
// Assumes the pad resolves oe low to a released (pulled-up) line.
module irq_pin_drv
    import irq_pkg::*;
(
    input  logic [1:0] style_i,
    input  logic       pend_i,
    output logic       pin_o,
    output logic       oe_o
);
    // Select drive per pin style; reserved style behaves as open drain
    always_comb begin
        case (style_i)
            STY_HIGH: begin pin_o = pend_i;  oe_o = 1'b1;   end
            STY_LOW:  begin pin_o = ~pend_i; oe_o = 1'b1;   end
            default:  begin pin_o = 1'b0;    oe_o = pend_i; end
        endcase
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the masked interrupt status controller.
// Holds the configuration registers, builds the two status registers and the
// receiver-error source, and drives the interrupt pin. Assumes events are
// synchronous to clk and ADDR_W >= 4.
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int ERR_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              tx_slip_i,
    input  logic              out_slip_i,
    input  logic              cs_de_i,
    input  logic              cs_ef_i,
    input  logic              ud_de_i,
    input  logic              ud_ef_i,
    input  logic              qblk_i,
    input  logic [ERR_W-1:0]  rx_err_i,
    output logic              irq_pin_o,
    output logic              irq_oe_o
);
    logic [1:0]       style_q;
    logic [REG_W-1:0] mask1_q, trh1_q, trl1_q;
    logic [REG_W-1:0] mask2_q, trh2_q, trl2_q;
    logic [ERR_W-1:0] erren_q;
    logic [REG_W-1:0] src1, src2, stat1, stat2, rd_mux, rdata_q;
    logic             err_any, clr1, clr2, pending;

    // Address decode of status reads (these reads clear edge bits)
    assign clr1 = reg_rd_i && (reg_addr_i == ADDR_W'(A_STAT1));
    assign clr2 = reg_rd_i && (reg_addr_i == ADDR_W'(A_STAT2));

    // Configuration register writes; status and unmapped writes are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style_q <= '0;
            mask1_q <= '0; trh1_q <= '0; trl1_q <= '0;
            mask2_q <= '0; trh2_q <= '0; trl2_q <= '0;
            erren_q <= '0;
        end else if (reg_wr_i) begin
            case (reg_addr_i)
                ADDR_W'(A_CTRL):  style_q <= reg_wdata_i[1:0];
                ADDR_W'(A_MASK1): mask1_q <= reg_wdata_i;
                ADDR_W'(A_TRH1):  trh1_q  <= reg_wdata_i;
                ADDR_W'(A_TRL1):  trl1_q  <= reg_wdata_i;
                ADDR_W'(A_MASK2): mask2_q <= reg_wdata_i;
                ADDR_W'(A_TRH2):  trh2_q  <= reg_wdata_i;
                ADDR_W'(A_TRL2):  trl2_q  <= reg_wdata_i;
                ADDR_W'(A_ERREN): erren_q <= reg_wdata_i[ERR_W-1:0];
                default: ;
            endcase
        end
    end

    irq_err_merge #(.ERR_W(ERR_W)) u_err (
        .err_i (rx_err_i),
        .en_i  (erren_q),
        .any_o (err_any)
    );

    assign src1 = {tx_slip_i, out_slip_i, 3'b000, cs_de_i, cs_ef_i, err_any};
    assign src2 = {4'b0000, ud_de_i, ud_ef_i, qblk_i, 1'b0};

    irq_stat_bank #(.IMPL(IMPL_ONE)) u_bank1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src1),
        .trig_hi_i (trh1_q),
        .trig_lo_i (trl1_q),
        .clr_i     (clr1),
        .stat_o    (stat1)
    );

    irq_stat_bank #(.IMPL(IMPL_TWO)) u_bank2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src2),
        .trig_hi_i (trh2_q),
        .trig_lo_i (trl2_q),
        .clr_i     (clr2),
        .stat_o    (stat2)
    );

    assign pending = |(stat1 & mask1_q) | |(stat2 & mask2_q);

    irq_pin_drv u_pin (
        .style_i (style_q),
        .pend_i  (pending),
        .pin_o   (irq_pin_o),
        .oe_o    (irq_oe_o)
    );

    // Read data selection by address
    always_comb begin
        case (reg_addr_i)
            ADDR_W'(A_CTRL):  rd_mux = REG_W'(style_q);
            ADDR_W'(A_STAT1): rd_mux = stat1;
            ADDR_W'(A_STAT2): rd_mux = stat2;
            ADDR_W'(A_MASK1): rd_mux = mask1_q;
            ADDR_W'(A_TRH1):  rd_mux = trh1_q;
            ADDR_W'(A_TRL1):  rd_mux = trl1_q;
            ADDR_W'(A_MASK2): rd_mux = mask2_q;
            ADDR_W'(A_TRH2):  rd_mux = trh2_q;
            ADDR_W'(A_TRL2):  rd_mux = trl2_q;
            ADDR_W'(A_ERREN): rd_mux = REG_W'(erren_q);
            default:          rd_mux = '0;
        endcase
    end

    // Register the read data on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (reg_rd_i) rdata_q <= rd_mux;
    end

    assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irq_status_chk.sv
// Module: assertion checker for irq_status_ctrl, attached by bind below.
// Assumes the internal names of the top module (status, enables, triggers).
module irq_status_chk
    import irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  rdata,
    input logic [REG_W-1:0]  stat1,
    input logic [REG_W-1:0]  stat2,
    input logic [REG_W-1:0]  mask1,
    input logic [REG_W-1:0]  mask2,
    input logic [REG_W-1:0]  trh1,
    input logic [REG_W-1:0]  trl1,
    input logic [REG_W-1:0]  src1,
    input logic [1:0]        style,
    input logic              pin,
    input logic              oe
);
    // R9: driven styles always enable the output
    a_r9_push_pull_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STY_HIGH || style == STY_LOW) |-> oe);

    // R9: open-drain styles never drive the data high
    a_r9_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
        style[1] |-> !pin);

    // R8: nothing enabled and set keeps an active-high pin low
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (((stat1 & mask1) == '0) && ((stat2 & mask2) == '0) && style == STY_HIGH) |-> !pin);

    // R3: unimplemented status positions read back as zero
    a_r3_stat1_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADDR_W'(A_STAT1)) |=> ((rdata & ~IMPL_ONE) == '0));

    for (genvar k = 0; k < REG_W; k++) begin : g_chk
        if (IMPL_ONE[k]) begin : g_impl
            // R5: a level bit equals the source sampled one edge earlier
            a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
                trh1[k] |=> (!trh1[k] || stat1[k] == $past(src1[k])));

            // R4: a latched edge bit stays set until a read of its register
            a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (stat1[k] && !trh1[k] && !(rd && addr == ADDR_W'(A_STAT1)))
                |=> (stat1[k] || trh1[k]));
        end
    end

    // R4: trigger-low register is only meaningful with trh; keep it referenced
    a_r4_fall_code_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(trl1));
endmodule

bind irq_status_ctrl irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (reg_rd_i),
    .addr  (reg_addr_i),
    .rdata (reg_rdata_o),
    .stat1 (stat1),
    .stat2 (stat2),
    .mask1 (mask1_q),
    .mask2 (mask2_q),
    .trh1  (trh1_q),
    .trl1  (trl1_q),
    .src1  (src1),
    .style (style_q),
    .pin   (irq_pin_o),
    .oe    (irq_oe_o)
);

// File: tb/test_irq_status_ctrl.sv
// Bench: level-mode vector table, then directed tests for edges and corners.
module test_irq_status_ctrl;
    import irq_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx = 0, os = 0, cde = 0, cef = 0, ude = 0, uef = 0, qb = 0;
    logic [6:0] rx_err = '0;
    logic       pin, oe;
    int         errors = 0, checks = 0;
    logic [7:0] v;

    always #10 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .tx_slip_i(tx), .out_slip_i(os), .cs_de_i(cde), .cs_ef_i(cef),
        .ud_de_i(ude), .ud_ef_i(uef), .qblk_i(qb), .rx_err_i(rx_err),
        .irq_pin_o(pin), .irq_oe_o(oe)
    );

    typedef struct packed {
        logic [3:0] a;   // {tx, os, cde, cef}
        logic [2:0] u;   // {ude, uef, qb}
        logic [6:0] e;
        logic [7:0] s1;
        logic [7:0] s2;
        logic       p;
    } vec_t;

    // Enables: one = 0x87, two = 0x0A, error enable = 0x7F, all level mode
    localparam vec_t TBL [11] = '{
        '{4'b0000, 3'b000, 7'h00, 8'h00, 8'h00, 1'b0},
        '{4'b1000, 3'b000, 7'h00, 8'h80, 8'h00, 1'b1},
        '{4'b0100, 3'b000, 7'h00, 8'h40, 8'h00, 1'b0},
        '{4'b0001, 3'b000, 7'h00, 8'h02, 8'h00, 1'b1},
        '{4'b0010, 3'b000, 7'h00, 8'h04, 8'h00, 1'b1},
        '{4'b0000, 3'b000, 7'h08, 8'h01, 8'h00, 1'b1},
        '{4'b0000, 3'b100, 7'h00, 8'h00, 8'h08, 1'b1},
        '{4'b0000, 3'b010, 7'h00, 8'h00, 8'h04, 1'b0},
        '{4'b0000, 3'b001, 7'h00, 8'h00, 8'h02, 1'b1},
        '{4'b1111, 3'b111, 7'h7F, 8'hC7, 8'h0E, 1'b1},
        '{4'b0100, 3'b010, 7'h00, 8'h40, 8'h04, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_pin(input string req, input logic ep, input logic eo);
        chk(req, {6'd0, pin, oe}, {6'd0, ep, eo});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk_pin("R1 pin after reset", 1'b0, 1'b1);
        chk("R1 rdata after reset", reg_rdata, 8'h00);
        rd(A_STAT1, v); chk("R1 status one after reset", v, 8'h00);

        // Table in level mode: R3 layout, R5 level, R7 composite, R8 enables
        wr(A_TRH1, 8'hFF); wr(A_TRH2, 8'hFF);
        wr(A_MASK1, 8'h87); wr(A_MASK2, 8'h0A); wr(A_ERREN, 8'h7F);
        for (int i = 0; i < 11; i++) begin
            {tx, os, cde, cef} = TBL[i].a;
            {ude, uef, qb} = TBL[i].u;
            rx_err = TBL[i].e;
            step();
            chk_pin("R8 table pin", TBL[i].p, 1'b1);
            rd(A_STAT1, v); chk("R3 table status one", v, TBL[i].s1);
            rd(A_STAT2, v); chk("R5 table status two", v, TBL[i].s2);
        end
        {tx, os, cde, cef, ude, uef, qb} = '0; rx_err = '0;
        step();
        wr(A_TRH1, 8'h00); wr(A_TRH2, 8'h00);
        wr(A_MASK1, 8'hFF); wr(A_MASK2, 8'hFF);

        // R4: rising edge latches and is cleared by a read
        tx = 1; step(); chk_pin("R4 rise latched", 1'b1, 1'b1);
        tx = 0; step(); chk_pin("R4 sticky after source drop", 1'b1, 1'b1);
        rd(A_STAT1, v); chk("R4 read latched", v, 8'h80);
        chk_pin("R4 pin after clear", 1'b0, 1'b1);
        rd(A_STAT1, v); chk("R4 cleared by read", v, 8'h00);

        // R4: falling code ignores rise, latches on fall
        wr(A_TRL1, 8'h40);
        os = 1; step(); rd(A_STAT1, v); chk("R4 fall code ignores rise", v, 8'h00);
        os = 0; step(); rd(A_STAT1, v); chk("R4 fall code latches", v, 8'h40);
        wr(A_TRL1, 8'h00);

        // R5: level (10) and reserved (11) follow the source, not cleared
        wr(A_TRH1, 8'h06); wr(A_TRL1, 8'h02);
        cde = 1; cef = 1; step();
        rd(A_STAT1, v); chk("R5 level and reserved set", v, 8'h06);
        rd(A_STAT1, v); chk("R5 level not cleared by read", v, 8'h06);
        cde = 0; cef = 0; step();
        rd(A_STAT1, v); chk("R5 level follows drop", v, 8'h00);
        wr(A_TRH1, 8'h00); wr(A_TRL1, 8'h00);
        rd(A_STAT1, v); chk("R5 nothing latched in level mode", v, 8'h00);

        // R6: edge in the same cycle as the read is kept
        reg_rd = 1; reg_addr = A_STAT1; tx = 1;
        @(negedge clk);
        reg_rd = 0;
        chk("R6 race read returns old", reg_rdata, 8'h00);
        rd(A_STAT1, v); chk("R6 race edge kept", v, 8'h80);
        tx = 0; step();

        // R7: only enabled error lines form the error source
        wr(A_ERREN, 8'h10);
        rx_err = 7'h08; step(); rd(A_STAT1, v); chk("R7 disabled error ignored", v, 8'h00);
        rx_err = 7'h18; step(); rd(A_STAT1, v); chk("R7 enabled error latched", v, 8'h01);
        rx_err = 7'h00; step(); rd(A_STAT1, v); chk("R7 cleared", v, 8'h00);

        // R10: status and unmapped writes ignored, unmapped read zero
        wr(A_STAT1, 8'hFF); rd(A_STAT1, v); chk("R10 status one write ignored", v, 8'h00);
        wr(A_STAT2, 8'hFF); rd(A_STAT2, v); chk("R10 status two write ignored", v, 8'h00);
        wr(4'hF, 8'hFF); rd(4'hF, v); chk("R10 unmapped read", v, 8'h00);
        chk_pin("R10 pin unchanged", 1'b0, 1'b1);

        // R2: readback of writable registers
        wr(A_MASK2, 8'h5A); rd(A_MASK2, v); chk("R2 enable two readback", v, 8'h5A);
        wr(A_ERREN, 8'hFF); rd(A_ERREN, v); chk("R2 error enable width", v, 8'h7F);
        wr(A_TRH2, 8'h33); rd(A_TRH2, v); chk("R2 trigger-high two", v, 8'h33);
        wr(A_TRH2, 8'h00);
        wr(A_CTRL, 8'hFF); rd(A_CTRL, v); chk("R2 control readback", v, 8'h03);
        wr(A_CTRL, 8'h00);

        // R8: enable gates the pin
        wr(A_MASK1, 8'h00);
        tx = 1; step(); chk_pin("R8 disabled source quiet", 1'b0, 1'b1);
        wr(A_MASK1, 8'h80); chk_pin("R8 enabling asserts", 1'b1, 1'b1);

        // R9: pin styles, pending then idle
        wr(A_CTRL, 8'h01); chk_pin("R9 low style pending", 1'b0, 1'b1);
        wr(A_CTRL, 8'h02); chk_pin("R9 open drain pending", 1'b0, 1'b1);
        wr(A_CTRL, 8'h03); chk_pin("R9 reserved pending", 1'b0, 1'b1);
        rd(A_STAT1, v); chk("R9 clear pending", v, 8'h80);
        chk_pin("R9 reserved idle", 1'b0, 1'b0);
        wr(A_CTRL, 8'h02); chk_pin("R9 open drain idle", 1'b0, 1'b0);
        wr(A_CTRL, 8'h01); chk_pin("R9 low style idle", 1'b1, 1'b1);
        wr(A_CTRL, 8'h00); chk_pin("R9 high style idle", 1'b0, 1'b1);

        // R1: reset while pending
        tx = 0; step(); tx = 1; step();
        chk_pin("R1 pending before reset", 1'b1, 1'b1);
        rst_n = 0; tx = 0; step(); step(); rst_n = 1; step();
        chk_pin("R1 pin after mid-run reset", 1'b0, 1'b1);
        rd(A_STAT1, v); chk("R1 status cleared by reset", v, 8'h00);
        rd(A_MASK1, v); chk("R1 enable cleared by reset", v, 8'h00);

        finish_run();
    end
endmodule